// File: doc/BRIEF.md
# Snapshot MAC Statistics Counter Bank

This block keeps the event statistics of a 10G Ethernet MAC. Each counter is 40 bits wide. The MAC datapath classifies its frames and raises one pulse per counter per event. A frame counter adds one for each pulse. An octet counter adds the byte count that comes with its pulse. The choice between frame and octet counting is made per counter by a parameter mask.

A host reads the counters through a small synchronous register port. It first writes a snapshot command. That command copies every live counter into a shadow bank in one cycle, so a counter that is read as three 16-bit words stays coherent even while traffic keeps counting.

A 64-bit rollover bitmap records which counters have wrapped past all ones. The bitmap is read as four 16-bit words, and reading a word clears it. Software can therefore poll for wraps and extend the counters past 40 bits. A clear command zeroes the live counters, the shadow bank and the bitmap in a single cycle.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every live counter, every shadow counter and every rollover flag is zero, and `reg_rdata` is zero.
- R2: A pulse on `evt_pulse[i]` adds one to live counter i when i is a frame counter (bit i of `OCTET_MASK` clear). It adds lane i of `evt_bytes` when i is an octet counter (bit i set). A counter with no pulse keeps its value.
- R3: Writing address 0x000 with data bit 0 set (snapshot) copies all live counters into the shadow bank at the same clock edge. The shadow bank does not change again until the next snapshot or clear.
- R4: A pulse that arrives in the same cycle as a snapshot is added to the live counter but is missing from that snapshot. It appears in the next snapshot.
- R5: Counter i is read from the shadow bank at address 0x010 + 4*i:
  - offset +0 returns bits 15:0;
  - offset +1 returns bits 31:16;
  - offset +2 returns bits 39:32 in bits 7:0, with bits 15:8 zero;
  - offset +3 returns zero.
- R6: A read request (`reg_rd` high) puts its data on `reg_rdata` in the following cycle. In any cycle that does not follow a read request, `reg_rdata` is zero.
- R7: When a live counter passes from all ones back through zero (modulo 2^40), its rollover flag is set, and the counter keeps the remainder. Flag i is bit i%16 of the rollover word at address 0x004 + i/16.
- R8: Reading a rollover word returns its flags and then clears only that word. A wrap in the same cycle as that read survives and shows up on the next read. Flags that read as set but were never caused by a wrap do not appear.
- R9: Writing address 0x000 with data bit 1 set (clear) zeroes all live counters, shadow counters and rollover flags at the next edge. Clear takes precedence over a snapshot and over pulses in the same cycle.
- R10: Writes to any address other than 0x000 are ignored, and so are the data bits other than bits 0 and 1. Reads of address 0x000 and of any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_CTR | One event pulse per counter |
| evt_bytes | input | NUM_CTR*BYTE_W | Per-counter byte count, lane i at bits i*BYTE_W +: BYTE_W |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |

## Verification
The bench sets the host read of a rollover word in the exact cycle that an octet counter wraps. A design that lets the clear-on-read win would lose that wrap for good. A snapshot is issued together with pulses, and a design that copied the post-increment value would show the extra events one snapshot early. Clear is issued together with snapshot and pulses, so that a wrong priority leaves residue in the counters. The upper 8-bit fragment, the zero fourth offset, and writes to unmapped or reserved bits are all checked, because a sloppy decode would leak data into them.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  // Counter width is fixed: the 16/16/8 fragment layout depends on it.
  localparam int unsigned STAT_CTR_W = 40;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned RO_WORDS   = 4;
  localparam int unsigned RO_BITS    = RO_WORDS * REG_W;
  // Word addresses of the register map.
  localparam int unsigned CTRL_OFS   = 0;
  localparam int unsigned RO_OFS     = 4;
  localparam int unsigned CTR_OFS    = 16;
  // Control register bits.
  localparam int unsigned SNAP_BIT   = 0;
  localparam int unsigned CLR_BIT    = 1;

  typedef logic [STAT_CTR_W-1:0] stat_t;

  typedef struct packed {
    logic  wrapped;
    stat_t value;
  } stat_sum_t;

  // Modular add that also reports the carry out of the top bit.
  function automatic stat_sum_t stat_add(stat_t cur, stat_t inc);
    logic [STAT_CTR_W:0] s;
    stat_sum_t r;
    s = {1'b0, cur} + {1'b0, inc};
    r.wrapped = s[STAT_CTR_W];
    r.value   = s[STAT_CTR_W-1:0];
    return r;
  endfunction

  // Selects one 16-bit read fragment of a counter.
  function automatic logic [REG_W-1:0] stat_frag(stat_t v, logic [1:0] sel);
    logic [REG_W-1:0] r;
    case (sel)
      2'd0:    r = v[15:0];
      2'd1:    r = v[31:16];
      2'd2:    r = {8'h00, v[39:32]};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell
  import mac_stat_pkg::*;
#(
  parameter int unsigned BYTE_W   = 16,
  parameter bit          IS_OCTET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [BYTE_W-1:0] bytes,
  input  logic              snap,
  input  logic              clr,
  output stat_t             live,
  output stat_t             shadow,
  output logic              wrap
);
  stat_t     inc;
  stat_sum_t sum;

  generate
    if (IS_OCTET) begin : g_octet
      assign inc = stat_t'(bytes);
    end else begin : g_frame
      logic unused_bytes;
      assign unused_bytes = ^bytes;
      assign inc = stat_t'(1);
    end
  endgenerate

  assign sum  = stat_add(live, inc);
  assign wrap = evt & sum.wrapped & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
    end else if (clr) begin
      live   <= '0;
      shadow <= '0;
    end else begin
      if (snap) shadow <= live;   // pre-increment value
      if (evt)  live   <= sum.value;
    end
  end
endmodule

// File: rtl/stat_rollover_map.sv
module stat_rollover_map
  import mac_stat_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [NUM_CTR-1:0]  wrap,
  input  logic [RO_WORDS-1:0] rd_word,
  output logic [RO_BITS-1:0]  flags
);
  logic unused_rd;
  assign unused_rd = ^rd_word;

  generate
    for (genvar b = 0; b < RO_BITS; b++) begin : g_bit
      if (b < NUM_CTR) begin : g_live
        always_ff @(posedge clk) begin
          if (!rst_n)   flags[b] <= 1'b0;
          else if (clr) flags[b] <= 1'b0;
          else          flags[b] <= (flags[b] & ~rd_word[b / REG_W]) | wrap[b];
        end
      end else begin : g_tie
        assign flags[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/stat_reg_decode.sv
module stat_reg_decode
  import mac_stat_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [REG_W-1:0]              wdata,
  input  logic [NUM_CTR*STAT_CTR_W-1:0] shadow_flat,
  input  logic [RO_BITS-1:0]            flags,
  output logic                          snap,
  output logic                          clr,
  output logic [RO_WORDS-1:0]           rd_word,
  output logic [REG_W-1:0]              rdata
);
  logic              ctrl_hit;
  logic              ro_hit;
  logic              ctr_zone;
  logic [ADDR_W-1:0] ctr_off;
  logic [REG_W-1:0]  rd_val;
  logic              unused_bits;

  assign unused_bits = ^{wdata[REG_W-1:2], ctr_off[1:0]};

  assign ctrl_hit = (addr == ADDR_W'(CTRL_OFS));
  assign ro_hit   = (addr[ADDR_W-1:2] == (ADDR_W-2)'(RO_OFS / 4));
  assign ctr_zone = (addr >= ADDR_W'(CTR_OFS));
  assign ctr_off  = addr - ADDR_W'(CTR_OFS);

  assign snap = wr & ctrl_hit & wdata[SNAP_BIT];
  assign clr  = wr & ctrl_hit & wdata[CLR_BIT];

  generate
    for (genvar w = 0; w < RO_WORDS; w++) begin : g_rdw
      assign rd_word[w] = rd & ro_hit & (addr[1:0] == 2'(w));
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    if (ro_hit) begin
      rd_val = flags[{addr[1:0], 4'b0000} +: REG_W];
    end else if (ctr_zone) begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (ctr_off[ADDR_W-1:2] == (ADDR_W-2)'(i))
          rd_val = stat_frag(shadow_flat[i*STAT_CTR_W +: STAT_CTR_W], addr[1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_val : '0;
  end
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int unsigned NUM_CTR    = 8,
  parameter int unsigned BYTE_W     = 16,
  parameter int unsigned ADDR_W     = 10,
  parameter logic [63:0] OCTET_MASK = 64'h0000_0000_0000_0011
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CTR-1:0]        evt_pulse,
  input  logic [NUM_CTR*BYTE_W-1:0] evt_bytes,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [15:0]               reg_wdata,
  output logic [15:0]               reg_rdata
);
  // NUM_CTR <= 64, BYTE_W <= 40, CTR_OFS + 4*NUM_CTR <= 2**ADDR_W.
  localparam int unsigned FLAT_W = NUM_CTR * STAT_CTR_W;

  // Named internal events, also observed by the bound checker.
  logic                  snap_cmd;
  logic                  clr_cmd;
  logic [RO_WORDS-1:0]   ro_rd_word;
  logic [NUM_CTR-1:0]    wrap_vec;
  logic [RO_BITS-1:0]    wrap_ext;
  logic [RO_BITS-1:0]    ro_flags;
  logic [FLAT_W-1:0]     live_flat;
  logic [FLAT_W-1:0]     shadow_flat;

  assign wrap_ext = RO_BITS'(wrap_vec);

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      stat_ctr_cell #(
        .BYTE_W  (BYTE_W),
        .IS_OCTET(OCTET_MASK[g])
      ) cell_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_pulse[g]),
        .bytes (evt_bytes[g*BYTE_W +: BYTE_W]),
        .snap  (snap_cmd),
        .clr   (clr_cmd),
        .live  (live_flat[g*STAT_CTR_W +: STAT_CTR_W]),
        .shadow(shadow_flat[g*STAT_CTR_W +: STAT_CTR_W]),
        .wrap  (wrap_vec[g])
      );
    end
  endgenerate

  stat_rollover_map #(.NUM_CTR(NUM_CTR)) ro_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_cmd),
    .wrap   (wrap_vec),
    .rd_word(ro_rd_word),
    .flags  (ro_flags)
  );

  stat_reg_decode #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (reg_addr),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .wdata      (reg_wdata),
    .shadow_flat(shadow_flat),
    .flags      (ro_flags),
    .snap       (snap_cmd),
    .clr        (clr_cmd),
    .rd_word    (ro_rd_word),
    .rdata      (reg_rdata)
  );
endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk #(
  parameter int unsigned FLAT_W = 320
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [15:0]       reg_rdata,
  input logic              snap_cmd,
  input logic              clr_cmd,
  input logic [FLAT_W-1:0] live_flat,
  input logic [FLAT_W-1:0] shadow_flat,
  input logic [63:0]       ro_flags,
  input logic [63:0]       wrap_ext
);
  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (live_flat == '0 && shadow_flat == '0 && ro_flags == '0));

  assert_snapshot_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cmd && !clr_cmd) |=> (shadow_flat == $past(live_flat)));

  assert_shadow_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_cmd && !clr_cmd) |=> $stable(shadow_flat));

  assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == 16'h0000));

  assert_wrap_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> ((ro_flags & $past(wrap_ext)) == $past(wrap_ext)));

  assert_no_spurious_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> ((ro_flags & ~$past(ro_flags) & ~$past(wrap_ext)) == 64'h0));
endmodule

bind mac_stat_bank mac_stat_bank_chk #(.FLAT_W(FLAT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .snap_cmd   (snap_cmd),
  .clr_cmd    (clr_cmd),
  .live_flat  (live_flat),
  .shadow_flat(shadow_flat),
  .ro_flags   (ro_flags),
  .wrap_ext   (wrap_ext)
);

// File: tb/mac_stat_bank_tb_top.sv
`timescale 1ns/1ps
module mac_stat_bank_tb_top;
  localparam int NUM = 8;
  localparam int BW  = 32;
  localparam int AW  = 10;
  localparam logic [63:0] MASK = 64'h11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM-1:0]    evt_pulse = '0;
  logic [NUM*BW-1:0] evt_bytes = '0;
  logic [AW-1:0]     reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;

  always #10 clk = ~clk;

  mac_stat_bank #(.NUM_CTR(NUM), .BYTE_W(BW), .ADDR_W(AW), .OCTET_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_bytes(evt_bytes),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Behavioural reference state.
  logic [39:0] m_live   [NUM];
  logic [39:0] m_shadow [NUM];
  logic [63:0] m_flags;
  logic [15:0] exp_rdata;
  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic model_step();
    int a;
    logic [40:0] s;
    logic [39:0] v;
    exp_rdata = 16'h0;
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) begin m_live[i] = '0; m_shadow[i] = '0; end
      m_flags = '0;
      return;
    end
    a = int'(reg_addr);
    if (reg_rd) begin
      if (a >= 4 && a < 8) exp_rdata = m_flags[(a-4)*16 +: 16];
      else if (a >= 16 && (a-16)/4 < NUM) begin
        v = m_shadow[(a-16)/4];
        case ((a-16)%4)
          0: exp_rdata = v[15:0];
          1: exp_rdata = v[31:16];
          2: exp_rdata = {8'h00, v[39:32]};
          default: exp_rdata = 16'h0;
        endcase
      end
      if (a >= 4 && a < 8) m_flags[(a-4)*16 +: 16] = 16'h0;
    end
    if (reg_wr && a == 0 && reg_wdata[1]) begin
      for (int i = 0; i < NUM; i++) begin m_live[i] = '0; m_shadow[i] = '0; end
      m_flags = '0;
      return;
    end
    for (int i = 0; i < NUM; i++) begin
      if (reg_wr && a == 0 && reg_wdata[0]) m_shadow[i] = m_live[i];
      if (evt_pulse[i]) begin
        s = {1'b0, m_live[i]} + (MASK[i] ? {9'h0, evt_bytes[i*BW +: BW]} : 41'd1);
        if (s[40]) m_flags[i] = 1'b1;
        m_live[i] = s[39:0];
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compared++;
    if (reg_rdata !== exp_rdata) begin
      mismatched++;
      $display("FAIL %s rdata actual=%h expected=%h at %0t", cur_req, reg_rdata, exp_rdata, $time);
    end
  endtask

  task automatic idle_inputs();
    evt_pulse = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic do_read(input int a);
    reg_addr = AW'(a); reg_rd = 1; tick(); idle_inputs();
  endtask

  task automatic do_write(input int a, input logic [15:0] d);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1; tick(); idle_inputs();
  endtask

  task automatic set_bytes(input logic [31:0] base);
    for (int i = 0; i < NUM; i++) evt_bytes[i*BW +: BW] = base + 32'(i * 7);
  endtask

  task automatic read_counter(input int i);
    for (int k = 0; k < 4; k++) do_read(16 + 4*i + k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    tick();
    do_read(0); do_read(4); read_counter(0); read_counter(NUM-1);

    // R2: frame and octet counting with varied byte counts
    cur_req = "R2";
    for (int c = 0; c < 20; c++) begin
      evt_pulse = NUM'(c * 37 + 5);
      set_bytes(32'(64 + c * 100));
      tick();
    end
    idle_inputs();
    cur_req = "R3";
    do_write(0, 16'h0001);
    // R5: fragment layout of every counter
    cur_req = "R5";
    for (int i = 0; i < NUM; i++) read_counter(i);

    // R3: shadow holds while live keeps counting
    cur_req = "R3";
    for (int c = 0; c < 6; c++) begin evt_pulse = '1; set_bytes(32'd1500); tick(); end
    idle_inputs();
    read_counter(0); read_counter(2);

    // R4: pulses in the snapshot cycle are excluded, then included next time
    cur_req = "R4";
    evt_pulse = '1; set_bytes(32'd9000);
    reg_addr = '0; reg_wdata = 16'h0001; reg_wr = 1; tick(); idle_inputs();
    read_counter(0); read_counter(1);
    do_write(0, 16'h0001);
    read_counter(0); read_counter(1);

    // R6: back-to-back reads and idle cycles
    cur_req = "R6";
    reg_rd = 1;
    for (int k = 16; k < 24; k++) begin reg_addr = AW'(k); tick(); end
    idle_inputs();
    repeat (3) tick();

    // R7 / R8: wrap octet counters, read flags in the wrap cycle of counter 4
    cur_req = "R7";
    for (int c = 0; c < 300; c++) begin
      logic [40:0] pred;
      evt_pulse = 8'h11;
      evt_bytes[0*BW +: BW] = 32'hF000_0000;
      evt_bytes[4*BW +: BW] = 32'hFFFF_FFFF;
      pred = {1'b0, m_live[4]} + 41'h0_FFFF_FFFF;
      if (pred[40]) begin cur_req = "R8"; reg_addr = AW'(4); reg_rd = 1; end
      tick();
      reg_rd = 0; cur_req = "R7";
    end
    idle_inputs();
    cur_req = "R8";
    do_read(4); do_read(4); do_read(5); do_read(6); do_read(7);
    cur_req = "R7";
    do_write(0, 16'h0001);
    read_counter(0); read_counter(4);

    // R10: ignored writes and unmapped reads
    cur_req = "R10";
    do_write(1, 16'h0003);
    do_write(16, 16'h0003);
    do_write(0, 16'hFFFC);
    read_counter(0);
    do_read(0); do_read(8); do_read(15); do_read(16 + 4*NUM); do_read(1023);

    // R9: clear with snapshot and pulses in the same cycle
    cur_req = "R9";
    evt_pulse = '1; set_bytes(32'd77);
    reg_addr = '0; reg_wdata = 16'h0003; reg_wr = 1; tick(); idle_inputs();
    do_read(4);
    read_counter(0); read_counter(3);
    do_write(0, 16'h0001);
    read_counter(0); read_counter(3);
    evt_pulse = 8'h0A; tick(); idle_inputs();
    do_write(0, 16'h0001);
    cur_req = "R2";
    read_counter(1); read_counter(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule